// File: doc/BRIEF.md
# Circular Event Queue Append Engine

The block appends event words to a ring of 32-bit entries held in memory. A requester presents one 31-bit event value together with the queue's current descriptor: the ring's base address, a size code, the slot index where the next entry goes, the current generation bit and the sticky wrap flag. The engine forms the entry address and the stored word, which puts the generation bit on top of the event value. It issues a single write on a request/response memory port and, once the response arrives, hands back the new descriptor fields with a one-cycle completion pulse.

The generation bit inverts on each pass around the ring. A reader can therefore tell fresh entries from stale ones by comparing the top bit of each word with the generation it expects, and needs no shared tail pointer. The sticky wrap flag is reloaded with the new generation at each wrap, so firmware can see that at least one wrap has occurred. If the memory write fails, the descriptor comes back unchanged and an error bit is raised alongside the completion pulse.

Top module: `ringq_push_engine`

## Requirements
- R1: After reset `busy`, `memReq` and `doneValid` are all low.
- R2: The write address equals `baseAddr + 4 * curIndex`, using the values sampled when the request is accepted.
- R3: The stored word has the generation bit in bit 31 and event bits 30..0 below it. It is presented big-endian: `memWrData[7:0]` carries word bits 31..24, `[15:8]` carries 23..16, `[23:16]` carries 15..8 and `[31:24]` carries 7..0.
- R4: On a successful write `doneIndex` equals `(curIndex + 1) mod 2^(sizeCode + 10)`. Size code 0 therefore gives 1024 entries, and the largest code gives 2^(10 + 2^SIZE_W - 1) entries.
- R5: When the advanced index is 0, `doneGen` is the inverse of `curGen` and `doneFlip` equals that new generation. Otherwise `doneGen` equals `curGen` and `doneFlip` equals `curFlip`.
- R6: When `memErr` is high with the response, `doneErr` is 1 and `doneIndex`, `doneGen` and `doneFlip` equal the request's `curIndex`, `curGen` and `curFlip`. Otherwise `doneErr` is 0.
- R7: A request (`reqValid` high while `busy` is low) is accepted on a clock edge. `busy` is high from the next cycle until the edge that samples `memRsp`. A request presented while `busy` is high is ignored and changes neither the pending write nor the returned fields.
- R8: `memReq` rises in the cycle after acceptance and stays high, with `memWrAddr` and `memWrData` stable, until the edge that samples `memRsp`.
- R9: `doneValid` is high for exactly one cycle, the cycle after the edge that samples `memRsp`, and `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Append request |
| reqData | input | DATA_W (31) | Event value to store |
| baseAddr | input | ADDR_W (48) | Byte address of ring slot 0 |
| sizeCode | input | SIZE_W (2) | Ring holds 2^(sizeCode+10) entries |
| curIndex | input | IDX_W (13) | Slot for this entry |
| curGen | input | 1 | Current generation bit |
| curFlip | input | 1 | Current sticky wrap flag |
| busy | output | 1 | An append is in flight |
| memReq | output | 1 | Memory write request, held until response |
| memWrAddr | output | ADDR_W (48) | Byte address of the entry |
| memWrData | output | 32 | Entry word in big-endian byte order |
| memRsp | input | 1 | Write response strobe |
| memErr | input | 1 | Write failed, valid with memRsp |
| doneValid | output | 1 | Completion pulse |
| doneIndex | output | IDX_W (13) | Updated slot index |
| doneGen | output | 1 | Updated generation bit |
| doneFlip | output | 1 | Updated sticky wrap flag |
| doneErr | output | 1 | Write failed, descriptor unchanged |

## Verification
The bench builds the engine with its default widths: a 48-bit address, a 2-bit size code and a 13-bit index. These values let it exercise every size code, including the largest 8192-entry ring. Each wrap is reached by starting the index at the last slot of the ring, rather than by walking thousands of entries. Because each size code gives a different wrap point, a mask derived from the wrong code shows up either as a missed wrap or as a false one. The default widths also cover an error response exactly at a wrap point, a request presented while busy, and responses that arrive with no delay.

// File: rtl/ringq_pkg.sv
package ringq_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture request and descriptor
    logic commit;  // memory response seen, produce results
    logic fail;    // response carried an error
  } ringq_strobe_t;
endpackage

// File: rtl/ringq_push_ctrl.sv
module ringq_push_ctrl
  import ringq_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          memRsp,
  input  logic          memErr,
  output ringq_strobe_t stb,
  output logic          busy,
  output logic          memReq,
  output logic          doneValid
);
  logic inWrite;

  always_comb begin
    stb.load   = !inWrite && reqValid;
    stb.commit = inWrite && memRsp;
    stb.fail   = inWrite && memRsp && memErr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inWrite   <= 1'b0;
      doneValid <= 1'b0;
    end else begin
      doneValid <= stb.commit;
      if (stb.load)        inWrite <= 1'b1;
      else if (stb.commit) inWrite <= 1'b0;
    end
  end

  assign busy   = inWrite;
  assign memReq = inWrite;
endmodule

// File: rtl/ringq_push_dp.sv
module ringq_push_dp
  import ringq_pkg::*;
#(
  parameter int ADDR_W    = 48,
  parameter int DATA_W    = 31,
  parameter int SIZE_W    = 2,
  parameter int IDX_W     = 13,
  parameter bit BYTE_SWAP = 1'b1
)(
  input  logic              clk,
  input  logic              rstN,
  input  ringq_strobe_t     stb,
  input  logic [DATA_W-1:0] reqData,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [SIZE_W-1:0] sizeCode,
  input  logic [IDX_W-1:0]  curIndex,
  input  logic              curGen,
  input  logic              curFlip,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [31:0]       memWrData,
  output logic [IDX_W-1:0]  doneIndex,
  output logic              doneGen,
  output logic              doneFlip,
  output logic              doneErr
);
  localparam int MAX_CODE = (1 << SIZE_W) - 1;
  localparam logic [IDX_W-1:0] ONES = {IDX_W{1'b1}};
  localparam int BYTES = 4;

  logic [ADDR_W-1:0] baseQ;
  logic [SIZE_W-1:0] codeQ;
  logic [IDX_W-1:0]  idxQ;
  logic              genQ, flipQ;
  logic [DATA_W-1:0] dataQ;

  logic [IDX_W-1:0]  entryMask, nextIdx;
  logic              wrap;
  logic [31:0]       word;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0; codeQ <= '0; idxQ <= '0;
      genQ  <= 1'b0; flipQ <= 1'b0; dataQ <= '0;
    end else if (stb.load) begin
      baseQ <= baseAddr; codeQ <= sizeCode; idxQ <= curIndex;
      genQ  <= curGen;   flipQ <= curFlip;  dataQ <= reqData;
    end
  end

  always_comb begin
    entryMask = ONES >> (SIZE_W'(MAX_CODE) - codeQ);
    nextIdx   = (idxQ + 1'b1) & entryMask;
    wrap      = (nextIdx == '0);
    word      = {genQ, dataQ};
  end

  assign memWrAddr = baseQ + ADDR_W'({idxQ, 2'b00});

  generate
    if (BYTE_SWAP) begin : g_be
      for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign memWrData[8*b +: 8] = word[8*(BYTES-1-b) +: 8];
      end
    end else begin : g_le
      assign memWrData = word;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneIndex <= '0; doneGen <= 1'b0; doneFlip <= 1'b0; doneErr <= 1'b0;
    end else if (stb.commit) begin
      doneErr <= stb.fail;
      if (stb.fail) begin
        doneIndex <= idxQ; doneGen <= genQ; doneFlip <= flipQ;
      end else begin
        doneIndex <= nextIdx;
        doneGen   <= wrap ? ~genQ : genQ;
        doneFlip  <= wrap ? ~genQ : flipQ;
      end
    end
  end
endmodule

// File: rtl/ringq_push_engine.sv
module ringq_push_engine
  import ringq_pkg::*;
#(
  parameter int ADDR_W    = 48,
  parameter int DATA_W    = 31,
  parameter int SIZE_W    = 2,
  parameter int IDX_W     = 10 + (1 << SIZE_W) - 1,
  parameter bit BYTE_SWAP = 1'b1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [DATA_W-1:0] reqData,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [SIZE_W-1:0] sizeCode,
  input  logic [IDX_W-1:0]  curIndex,
  input  logic              curGen,
  input  logic              curFlip,
  output logic              busy,
  output logic              memReq,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [31:0]       memWrData,
  input  logic              memRsp,
  input  logic              memErr,
  output logic              doneValid,
  output logic [IDX_W-1:0]  doneIndex,
  output logic              doneGen,
  output logic              doneFlip,
  output logic              doneErr
);
  ringq_strobe_t stb;

  ringq_push_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memRsp(memRsp),
    .memErr(memErr), .stb(stb), .busy(busy), .memReq(memReq),
    .doneValid(doneValid)
  );

  ringq_push_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W), .IDX_W(IDX_W),
    .BYTE_SWAP(BYTE_SWAP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqData(reqData),
    .baseAddr(baseAddr), .sizeCode(sizeCode), .curIndex(curIndex),
    .curGen(curGen), .curFlip(curFlip), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .doneIndex(doneIndex), .doneGen(doneGen),
    .doneFlip(doneFlip), .doneErr(doneErr)
  );
endmodule

// File: rtl/ringq_push_chk.sv
module ringq_push_chk #(
  parameter int ADDR_W = 48,
  parameter int IDX_W  = 13
)(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              busy,
  input logic              memReq,
  input logic [ADDR_W-1:0] memWrAddr,
  input logic [31:0]       memWrData,
  input logic              memRsp,
  input logic              doneValid,
  input logic [IDX_W-1:0]  doneIndex,
  input logic              doneGen,
  input logic              doneFlip,
  input logic              doneErr
);
  // R7
  accept_sets_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !busy |=> busy && memReq);

  // R8
  req_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memRsp |=> memReq && $stable(memWrAddr) && $stable(memWrData));

  // R9
  rsp_completes_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memRsp |=> doneValid && !busy);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R5
  wrap_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && !doneErr && doneIndex == '0 |-> doneFlip == doneGen);
endmodule

bind ringq_push_engine ringq_push_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .busy(busy), .memReq(memReq),
  .memWrAddr(memWrAddr), .memWrData(memWrData), .memRsp(memRsp),
  .doneValid(doneValid), .doneIndex(doneIndex), .doneGen(doneGen),
  .doneFlip(doneFlip), .doneErr(doneErr)
);

// File: tb/ringq_push_engine_bench.sv
module ringq_push_engine_bench;
  localparam int ADDR_W = 48;
  localparam int DATA_W = 31;
  localparam int SIZE_W = 2;
  localparam int IDX_W  = 13;

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [31:0]       data;
  } memItem_t;
  typedef struct {
    logic [IDX_W-1:0] idx;
    logic gen, flip, err;
  } doneItem_t;

  logic clk = 0, rstN = 0;
  logic reqValid = 0;
  logic [DATA_W-1:0] reqData = '0;
  logic [ADDR_W-1:0] baseAddr = '0;
  logic [SIZE_W-1:0] sizeCode = '0;
  logic [IDX_W-1:0]  curIndex = '0;
  logic curGen = 0, curFlip = 0, memRsp = 0, memErr = 0;
  logic busy, memReq, doneValid, doneGen, doneFlip, doneErr;
  logic [ADDR_W-1:0] memWrAddr;
  logic [31:0] memWrData;
  logic [IDX_W-1:0] doneIndex;

  int total = 0, bad = 0, cycles = 0;
  memItem_t memQ[$];
  doneItem_t doneQ[$];
  logic seenReq = 0;

  always #2 clk = ~clk;

  ringq_push_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W),
                      .IDX_W(IDX_W)) u_ringq_push_engine (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqData(reqData),
    .baseAddr(baseAddr), .sizeCode(sizeCode), .curIndex(curIndex),
    .curGen(curGen), .curFlip(curFlip), .busy(busy), .memReq(memReq),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .memRsp(memRsp),
    .memErr(memErr), .doneValid(doneValid), .doneIndex(doneIndex),
    .doneGen(doneGen), .doneFlip(doneFlip), .doneErr(doneErr)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: memory side (R2, R3, R8) and completion side (R4..R6, R9)
  always @(negedge clk) begin
    if (rstN && memReq && !seenReq) begin
      memItem_t m;
      seenReq = 1;
      if (memQ.size() == 0) check(0, "R2 unexpected write", 64'(memWrAddr), 0);
      else begin
        m = memQ.pop_front();
        check(memWrAddr == m.addr, "R2 address", 64'(memWrAddr), 64'(m.addr));
        check(memWrData == m.data, "R3 word", 64'(memWrData), 64'(m.data));
      end
    end
    if (!memReq) seenReq = 0;
    if (rstN && doneValid) begin
      doneItem_t d;
      check(!busy, "R9 busy low at done", 64'(busy), 0);
      if (doneQ.size() == 0) check(0, "R9 unexpected done", 1, 0);
      else begin
        d = doneQ.pop_front();
        check(doneIndex == d.idx, "R4/R6 index", 64'(doneIndex), 64'(d.idx));
        check(doneGen == d.gen && doneFlip == d.flip, "R5/R6 gen,flip",
              64'({doneGen, doneFlip}), 64'({d.gen, d.flip}));
        check(doneErr == d.err, "R6 error flag", 64'(doneErr), 64'(d.err));
      end
    end
  end

  // driver: computes expected items, drives the request and the memory reply
  task automatic push(input logic [DATA_W-1:0] d, input logic [ADDR_W-1:0] base,
                      input int code, input int idx, input bit gen, input bit flip,
                      input bit err, input int delay, input bit poke);
    memItem_t m;
    doneItem_t e;
    logic [31:0] w;
    int n, nx;
    n  = 1 << (code + 10);
    nx = (idx + 1) % n;
    w  = {gen, d};
    m.addr = base + ADDR_W'(idx) * 4;
    m.data = {w[7:0], w[15:8], w[23:16], w[31:24]};
    if (err) begin
      e.idx = IDX_W'(idx); e.gen = gen; e.flip = flip; e.err = 1;
    end else begin
      e.idx = IDX_W'(nx); e.err = 0;
      e.gen  = (nx == 0) ? ~gen : gen;
      e.flip = (nx == 0) ? ~gen : flip;
    end
    memQ.push_back(m);
    doneQ.push_back(e);
    reqData = d; baseAddr = base; sizeCode = SIZE_W'(code);
    curIndex = IDX_W'(idx); curGen = gen; curFlip = flip; reqValid = 1;
    @(negedge clk);
    reqValid = 0;
    check(busy && memReq, "R7/R8 busy and request after accept",
          64'({busy, memReq}), 64'(3));
    if (poke) begin
      reqData = ~d; baseAddr = base + 'h100; curIndex = IDX_W'(idx ^ 1);
      curGen = ~gen; reqValid = 1;
      @(negedge clk);
      reqValid = 0;
      check(memWrAddr == m.addr && !doneValid, "R7 request while busy ignored",
            64'(memWrAddr), 64'(m.addr));
    end
    repeat (delay) @(negedge clk);
    check(memReq && !doneValid, "R8 request held until response",
          64'(memReq), 1);
    memRsp = 1; memErr = err;
    @(negedge clk);
    memRsp = 0; memErr = 0;
    @(negedge clk);
    check(!doneValid, "R9 single-cycle done", 64'(doneValid), 0);
  endtask

  task automatic finishRun;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(!busy && !memReq && !doneValid, "R1 reset outputs",
          64'({busy, memReq, doneValid}), 0);
    rstN = 1;
    @(negedge clk);
    check(!busy && !memReq && !doneValid, "R1 idle after reset",
          64'({busy, memReq, doneValid}), 0);
    push(31'h7FFF_1234, 48'h0000_0001_0000, 0, 5, 1'b0, 1'b0, 0, 2, 0);
    push(31'h0000_0055, 48'h0000_0002_0000, 0, 1023, 1'b1, 1'b1, 0, 0, 0);
    push(31'h1234_5678, 48'h0000_0003_0000, 1, 1023, 1'b1, 1'b0, 0, 1, 0);
    push(31'h2AAA_AAAA, 48'h0000_0004_0000, 1, 2047, 1'b0, 1'b1, 0, 3, 0);
    push(31'h0000_0001, 48'h0000_0005_0000, 2, 4095, 1'b1, 1'b0, 0, 0, 0);
    push(31'h5555_0000, 48'hFFFF_0000_0000, 3, 8191, 1'b0, 1'b0, 0, 1, 0);
    push(31'h0F0F_0F0F, 48'h0000_0006_0000, 3, 4095, 1'b0, 1'b0, 0, 0, 0);
    push(31'h3333_3333, 48'h0000_0007_0000, 0, 1023, 1'b0, 1'b0, 1, 2, 0);
    push(31'h0000_0777, 48'h0000_0008_0000, 2, 100, 1'b1, 1'b1, 1, 0, 0);
    push(31'h4321_0000, 48'h0000_0009_0000, 1, 300, 1'b0, 1'b1, 0, 2, 1);
    push(31'h7FFF_FFFF, 48'h0000_000A_0000, 0, 0, 1'b1, 1'b0, 0, 1, 0);
    repeat (3) @(negedge clk);
    check(memQ.size() == 0 && doneQ.size() == 0, "R9 all results seen",
          64'(memQ.size() + doneQ.size()), 0);
    finishRun();
  end
endmodule